// File: doc/BRIEF.md
# Counted Reel Spinner

This block models one reel of a three-reel game. A one-cycle start request, taken while the reel is at rest, captures an 8-bit random spin length and clears an internal step counter. From then on the reel symbol advances by one position on every clock while the step counter climbs towards the captured length. When the two are equal the reel stops and raises a one-cycle done flag, so the game controller can read the resting symbol.

The resting symbol is a 2-bit state. An active-high 4-bit display pattern is decoded from it for a lamp column, drawn as no line, a single line or a double line of lights. Start requests that arrive while the reel is turning are dropped. Several instances, each fed by its own random source, make up the full set of reels.

Top module: `reel_spinner`

## Requirements
- R1: A start pulse accepted at rest makes the symbol advance by exactly one position per clock, modulo 4 (0, 1, 2, 3, 0, ...), and the symbol never changes in any other way.
- R2: With a captured length L, done goes high on the (L+1)-th rising edge after the edge that samples start.
- R3: After a spin of length L the symbol rests at (initial symbol + L) mod 4 and holds that value for as long as the reel is at rest.
- R4: A length of zero stops the reel at once: done rises on the first edge after the start edge and the symbol does not change.
- R5: Done stays high for exactly one clock cycle per spin.
- R6: A start pulse during a spin is ignored: neither the new random value nor the pulse changes the spin length or the final symbol.
- R7: The display pattern is decoded from the symbol: 0 gives 4'b0000 (no line), 1 gives 4'b0001 (one lower line), 2 gives 4'b0011 (double line), 3 gives 4'b1000 (one upper line); a 1 lights the lamp.
- R8: While reset (active low) is asserted, the symbol is 0, the pattern is 4'b0000, done is 0 and the reel is at rest, including when reset arrives mid-spin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Spin request, honoured only at rest |
| randVal | input | 8 | Random spin length sampled with start |
| symbol | output | 2 | Current reel symbol state |
| pattern | output | 4 | Active-high lamp pattern of the symbol |
| done | output | 1 | One-cycle pulse when the reel stops |

## Verification
A corrupted step counter or captured length shows at the ports as a done pulse on the wrong edge and, unless the error is a multiple of four, as a wrong resting symbol, both visible at the end of the very spin that suffered it. A wrong control state shows up within one cycle: a symbol that moves while the reel should be at rest, a done that lasts two cycles, or a spin that a mid-spin start restarts. Errors in the decode appear at once on the pattern for the affected symbol.

// File: rtl/reel_pkg.sv
package reel_pkg;
  localparam int SYM_W = 2;
  localparam int PAT_W = 4;

  typedef enum logic {
    REST = 1'b0,
    SPIN = 1'b1
  } reelState_t;

  typedef struct packed {
    logic load;
    logic step;
  } reelStrobe_t;

  function automatic logic [PAT_W-1:0] symToPattern(input logic [SYM_W-1:0] sym);
    logic [PAT_W-1:0] pat;
    case (sym)
      2'd0:    pat = 4'b0000;
      2'd1:    pat = 4'b0001;
      2'd2:    pat = 4'b0011;
      default: pat = 4'b1000;
    endcase
    return pat;
  endfunction
endpackage

// File: rtl/reel_ctrl.sv
module reel_ctrl
  import reel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        hit,
  output reelStrobe_t strobe,
  output logic        busy,
  output logic        done
);
  reelState_t state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    case (state)
      REST: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = SPIN;
        end
      end
      SPIN: begin
        if (hit) stateNext = REST;
        else     strobe.step = 1'b1;
      end
      default: stateNext = REST;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= REST;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == SPIN) && hit;
    end
  end

  assign busy = (state == SPIN);
endmodule

// File: rtl/reel_datapath.sv
module reel_datapath
  import reel_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  reelStrobe_t        strobe,
  input  logic [COUNT_W-1:0] randVal,
  output logic               hit,
  output logic [SYM_W-1:0]   symbol,
  output logic [PAT_W-1:0]   pattern
);
  logic [COUNT_W-1:0] target;
  logic [COUNT_W-1:0] stepCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      target    <= '0;
      stepCount <= '0;
      symbol    <= '0;
    end else if (strobe.load) begin
      target    <= randVal;
      stepCount <= '0;
    end else if (strobe.step) begin
      stepCount <= stepCount + 1'b1;
      symbol    <= symbol + 1'b1;
    end
  end

  assign hit     = (stepCount == target);
  assign pattern = symToPattern(symbol);
endmodule

// File: rtl/reel_spinner.sv
module reel_spinner
  import reel_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [COUNT_W-1:0] randVal,
  output logic [SYM_W-1:0]   symbol,
  output logic [PAT_W-1:0]   pattern,
  output logic               done
);
  reelStrobe_t strobe;
  logic        hit;
  logic        busy;

  reel_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .hit    (hit),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  reel_datapath #(.COUNT_W(COUNT_W)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .randVal (randVal),
    .hit     (hit),
    .symbol  (symbol),
    .pattern (pattern)
  );
endmodule

// File: rtl/reel_spinner_chk.sv
module reel_spinner_chk
  import reel_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             hit,
  input logic             load,
  input logic             done,
  input logic [SYM_W-1:0] symbol
);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(symbol) |-> (symbol == $past(symbol) + 2'd1) && $past(busy));

  assert_stop_on_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy) && $past(hit));

  assert_hold_at_rest_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(symbol));

  assert_no_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && start |-> !load);

  assert_keep_spinning_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy && !hit |=> busy);
endmodule

bind reel_spinner reel_spinner_chk i_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .busy   (busy),
  .hit    (hit),
  .load   (strobe.load),
  .done   (done),
  .symbol (symbol)
);

// File: tb/test_reel_spinner.sv
module test_reel_spinner;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [7:0] randVal = '0;
  logic [1:0] symbol;
  logic [3:0] pattern;
  logic       done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  reel_spinner i_reel_spinner (
    .clk(clk), .rstN(rstN), .start(start), .randVal(randVal),
    .symbol(symbol), .pattern(pattern), .done(done)
  );

  // spin length, expected resting symbol (starting from 0 after reset)
  localparam int NVEC = 8;
  localparam logic [9:0] VEC [NVEC] = '{
    {8'd1, 2'd1}, {8'd2, 2'd3}, {8'd0, 2'd3}, {8'd3, 2'd2},
    {8'd5, 2'd3}, {8'd255, 2'd2}, {8'd4, 2'd2}, {8'd6, 2'd0}
  };

  function automatic logic [3:0] expPat(input logic [1:0] s);
    case (s)
      2'd0: return 4'b0000;
      2'd1: return 4'b0001;
      2'd2: return 4'b0011;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse start with len; optionally pulse a second start at cycle ignAt.
  // Returns the cycle index (edges after the start edge) at which done is seen.
  task automatic spin(input logic [7:0] len, input int ignAt, output int doneAt,
                      output logic [1:0] firstSym);
    int n;
    @(negedge clk);
    randVal = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0; randVal = 8'hAA;
    n = 0; doneAt = -1; firstSym = 2'd0;
    while (doneAt < 0 && n < 400) begin
      @(negedge clk);
      n++;
      if (n == 1) firstSym = symbol;
      if (done) doneAt = n;
      if (n == ignAt) begin randVal = 8'd3; start = 1'b1; end
      else start = 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int doneAt;
    logic [1:0] firstSym;
    logic [1:0] prevSym;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 symbol in reset", symbol, 0);
    check("R8 pattern in reset", pattern, 0);
    check("R8 done in reset", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 at rest after reset", symbol, 0);

    prevSym = 2'd0;
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] len;
      logic [1:0] expSym;
      len = VEC[i][9:2];
      expSym = VEC[i][1:0];
      spin(len, -1, doneAt, firstSym);
      check("R2 done edge", doneAt, int'(len) + 1);
      if (len == 0) check("R4 zero length keeps symbol", firstSym, prevSym);
      else          check("R1 first step +1", firstSym, 2'(prevSym + 2'd1));
      check("R3 resting symbol", symbol, expSym);
      check("R7 pattern", pattern, expPat(symbol));
      @(negedge clk);
      check("R5 done one cycle", done, 0);
      repeat (3) @(negedge clk);
      check("R3 symbol held at rest", symbol, expSym);
      prevSym = expSym;
    end

    // R6: start during spin ignored (prevSym = 0, length 20)
    spin(8'd20, 5, doneAt, firstSym);
    check("R6 length unchanged by mid-spin start", doneAt, 21);
    check("R6 final symbol", symbol, 0);
    @(negedge clk);
    check("R5 done low after pulse", done, 0);
    repeat (6) @(negedge clk);
    check("R6 no restart after ignored start", symbol, 0);

    // R7: walk every symbol via length-1 spins
    for (int k = 1; k <= 4; k++) begin
      spin(8'd1, -1, doneAt, firstSym);
      check("R7 pattern per symbol", pattern, expPat(2'(k)));
      check("R1 wrap stepping", symbol, k % 4);
    end

    // R8: reset mid-spin
    @(negedge clk);
    randVal = 8'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 symbol after mid-spin reset", symbol, 0);
    check("R8 pattern after mid-spin reset", pattern, 0);
    check("R8 done after mid-spin reset", done, 0);
    rstN = 1'b1;
    begin
      int seen;
      seen = 0;
      for (int j = 0; j < 12; j++) begin
        @(negedge clk);
        if (done || symbol != 0) seen++;
      end
      check("R8 reel at rest after reset", seen, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule